// File: doc/BRIEF.md
# Read-Triggered Processor Sleep Controller

This block sits behind an I/O-mapped slave front end and turns plain read accesses into processor idle-state requests. Three byte-wide trigger locations sit at fixed offsets above a programmable power-management base. They hold no data. A read of one of them asks the clock control logic to put the processor into idle level 2, 3 or 4. The block then pulls its active-low stop-clock output low, reports the level on a 2-bit code, and stays in that level until a break event arrives.

Several access channels (parameter `N_PORT`, default 2) are decoded in parallel, so requests that arrive in the same cycle are resolved by a fixed priority. A promotion input turns level-3 requests into level-4 requests. Clock throttling from the throttle-enable and force-throttle sources reaches the stop-clock output only while the processor runs. Inside a sleep level the throttle has no effect.

Top module: `sleep_ctl`

## Requirements
- R1: A channel access is a trigger only when its valid bit is 1, its write bit is 0, address bits [15:7] equal `pm_base`, and address bits [6:0] are 14h (level 2), 15h (level 3) or 16h (level 4). Any other offset or base produces no request.
- R2: `rd_data` is 00h on every channel. A write access (`acc_wr`=1) to a trigger offset changes neither `sleep_lvl` nor `stpclk_n`.
- R3: A level-2 trigger taken while `sleep_lvl` is 0 sets `sleep_lvl` to 1 on the next clock edge, and `stpclk_n` goes low.
- R4: With `c4_on_c3`=0, a level-3 trigger from run sets `sleep_lvl` to 2 and a level-4 trigger sets it to 3, both on the next edge.
- R5: With `c4_on_c3`=1, a level-3 trigger from run sets `sleep_lvl` to 3.
- R6: Same-cycle triggers resolve by priority: level 2 over level 4 over level 3. A level-2 trigger together with a level-3 trigger gives `sleep_lvl`=1.
- R7: A non-zero `sleep_lvl` holds while `brk_evt` is 0. When `brk_evt` is 1 at an edge, `sleep_lvl` returns to 0 on that edge, and `stpclk_n` goes high if no throttle is active.
- R8: Triggers that arrive while `sleep_lvl` is not 0 are ignored. This includes triggers in the same cycle as a break event.
- R9: `sleep_lvl` is a 2-bit code: 0 means run, 1 means C2, 2 means C3 and 3 means C4. `stpclk_n` is low whenever `sleep_lvl` is non-zero.
- R10: While `sleep_lvl` is 0, `thr_act` = (`thr_en` | `thr_force`) & `thr_duty`, and `stpclk_n` = !`thr_act`. While `sleep_lvl` is non-zero, `thr_act` is 0.
- R11: After reset, `sleep_lvl` is 0 and `stpclk_n` is 1 (with throttle inputs low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_base | input | 9 | Power-management base, compared with address bits [15:7] |
| c4_on_c3 | input | 1 | Promote level-3 triggers to level 4 |
| acc_valid | input | N_PORT | Access strobe per channel |
| acc_wr | input | N_PORT | 1 = write access, 0 = read access |
| acc_addr | input | 16*N_PORT | Access address per channel, channel 0 in the low bits |
| rd_data | output | 8*N_PORT | Read data per channel, always 00h |
| brk_evt | input | 1 | Break event, ends any sleep level |
| thr_en | input | 1 | Throttle enable |
| thr_force | input | 1 | Forced throttle |
| thr_duty | input | 1 | Throttle duty phase from the throttle timer |
| stpclk_n | output | 1 | Active-low stop-clock request |
| sleep_lvl | output | 2 | Current idle level code |
| thr_act | output | 1 | Throttle is gating the clock |

## Verification
The assertions assume that `brk_evt`, the throttle inputs and the access channels are synchronous and stable around each rising clock edge. They also assume `pm_base` is static between accesses, because the decode-to-level properties compare a registered level against hits decoded in the previous cycle. The bench changes every input only on the falling edge. It keeps `pm_base` fixed for the whole run, and it raises a break event only as a single-cycle pulse. The same-cycle conflict cases are built by driving both channels in one cycle.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_C2  = 2'd1,
        ST_C3  = 2'd2,
        ST_C4  = 2'd3
    } slp_state_e;

    typedef struct packed {
        slp_state_e state;
    } ctl_reg_t;

    localparam logic [6:0] OFS_LVL2 = 7'h14;
    localparam logic [6:0] OFS_LVL3 = 7'h15;
    localparam logic [6:0] OFS_LVL4 = 7'h16;

endpackage

// File: rtl/sleep_trig_decode.sv
module sleep_trig_decode #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 7,
    localparam int BASE_W = ADDR_W - OFS_W
) (
    input  logic [BASE_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    input  logic              write,
    output logic              hit2,
    output logic              hit3,
    output logic              hit4
);
    import sleep_ctl_pkg::*;

    logic             rd_in_window;
    logic [OFS_W-1:0] ofs;

    always_comb begin
        rd_in_window = valid && !write && (addr[ADDR_W-1:OFS_W] == base);
        ofs          = addr[OFS_W-1:0];
        hit2 = rd_in_window && (ofs == OFS_W'(OFS_LVL2));
        hit3 = rd_in_window && (ofs == OFS_W'(OFS_LVL3));
        hit4 = rd_in_window && (ofs == OFS_W'(OFS_LVL4));
    end

endmodule

// File: rtl/sleep_req_arb.sv
module sleep_req_arb #(
    parameter int N_PORT = 2
) (
    input  logic [N_PORT-1:0]       hit2,
    input  logic [N_PORT-1:0]       hit3,
    input  logic [N_PORT-1:0]       hit4,
    input  logic                    c4_on_c3,
    output logic                    req_vld,
    output sleep_ctl_pkg::slp_state_e req_state
);
    import sleep_ctl_pkg::*;

    // Priority: level 2 first, then level 4 (direct or promoted), then level 3.
    always_comb begin
        req_vld   = 1'b1;
        req_state = ST_RUN;
        if (|hit2) begin
            req_state = ST_C2;
        end else if ((|hit4) || ((|hit3) && c4_on_c3)) begin
            req_state = ST_C4;
        end else if (|hit3) begin
            req_state = ST_C3;
        end else begin
            req_vld = 1'b0;
        end
    end

endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl #(
    parameter int N_PORT = 2,
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 7,
    parameter int DATA_W = 8,
    localparam int BASE_W = ADDR_W - OFS_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BASE_W-1:0]        pm_base,
    input  logic                     c4_on_c3,
    input  logic [N_PORT-1:0]        acc_valid,
    input  logic [N_PORT-1:0]        acc_wr,
    input  logic [N_PORT*ADDR_W-1:0] acc_addr,
    output logic [N_PORT*DATA_W-1:0] rd_data,
    input  logic                     brk_evt,
    input  logic                     thr_en,
    input  logic                     thr_force,
    input  logic                     thr_duty,
    output logic                     stpclk_n,
    output logic [1:0]               sleep_lvl,
    output logic                     thr_act
);
    import sleep_ctl_pkg::*;

    logic [N_PORT-1:0] hit2_v;
    logic [N_PORT-1:0] hit3_v;
    logic [N_PORT-1:0] hit4_v;
    logic              req_vld;
    slp_state_e        req_state;
    ctl_reg_t          ctl_d;
    ctl_reg_t          ctl_q;

    for (genvar gi = 0; gi < N_PORT; gi++) begin : g_dec
        sleep_trig_decode #(
            .ADDR_W (ADDR_W),
            .OFS_W  (OFS_W)
        ) u_dec (
            .base  (pm_base),
            .addr  (acc_addr[gi*ADDR_W +: ADDR_W]),
            .valid (acc_valid[gi]),
            .write (acc_wr[gi]),
            .hit2  (hit2_v[gi]),
            .hit3  (hit3_v[gi]),
            .hit4  (hit4_v[gi])
        );
        // Trigger locations carry no data.
        assign rd_data[gi*DATA_W +: DATA_W] = '0;
    end

    sleep_req_arb #(
        .N_PORT (N_PORT)
    ) u_arb (
        .hit2      (hit2_v),
        .hit3      (hit3_v),
        .hit4      (hit4_v),
        .c4_on_c3  (c4_on_c3),
        .req_vld   (req_vld),
        .req_state (req_state)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.state == ST_RUN) begin
            if (req_vld) begin
                ctl_d.state = req_state;
            end
        end else if (brk_evt) begin
            ctl_d.state = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_RUN};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        sleep_lvl = ctl_q.state;
        thr_act   = (thr_en || thr_force) && thr_duty && (ctl_q.state == ST_RUN);
        stpclk_n  = !((ctl_q.state != ST_RUN) || thr_act);
    end

endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk #(
    parameter int N_PORT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              c4_on_c3,
    input logic              brk_evt,
    input logic              thr_en,
    input logic              thr_force,
    input logic              thr_duty,
    input logic              stpclk_n,
    input logic [1:0]        sleep_lvl,
    input logic              thr_act,
    input logic [N_PORT-1:0] hit2_v,
    input logic [N_PORT-1:0] hit3_v,
    input logic [N_PORT-1:0] hit4_v
);

    p_lvl2_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl == 2'd0 && |hit2_v) |=> (sleep_lvl == 2'd1));

    p_lvl3_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl == 2'd0 && |hit3_v && !(|hit2_v) && !(|hit4_v) && !c4_on_c3)
        |=> (sleep_lvl == 2'd2));

    p_promote_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl == 2'd0 && |hit3_v && !(|hit2_v) && c4_on_c3) |=> (sleep_lvl == 2'd3));

    p_lvl4_over_lvl3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl == 2'd0 && |hit4_v && !(|hit2_v)) |=> (sleep_lvl == 2'd3));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl != 2'd0 && !brk_evt) |=> $stable(sleep_lvl));

    p_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl != 2'd0 && brk_evt) |=> (sleep_lvl == 2'd0));

    p_stpclk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl != 2'd0) |-> !stpclk_n);

    p_thr_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl != 2'd0) |-> !thr_act);

    p_thr_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_lvl == 2'd0) |-> (thr_act == ((thr_en || thr_force) && thr_duty)
                                 && stpclk_n == !thr_act));

endmodule

bind sleep_ctl sleep_ctl_chk #(.N_PORT(N_PORT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .c4_on_c3  (c4_on_c3),
    .brk_evt   (brk_evt),
    .thr_en    (thr_en),
    .thr_force (thr_force),
    .thr_duty  (thr_duty),
    .stpclk_n  (stpclk_n),
    .sleep_lvl (sleep_lvl),
    .thr_act   (thr_act),
    .hit2_v    (hit2_v),
    .hit3_v    (hit3_v),
    .hit4_v    (hit4_v)
);

// File: tb/sleep_ctl_tb.sv
module sleep_ctl_tb;

    localparam logic [8:0] BASE = 9'h008; // address 0400h

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  pm_base = BASE;
    logic        c4_on_c3 = 1'b0;
    logic [1:0]  acc_valid = '0;
    logic [1:0]  acc_wr = '0;
    logic [31:0] acc_addr = '0;
    logic [15:0] rd_data;
    logic        brk_evt = 1'b0;
    logic        thr_en = 1'b0;
    logic        thr_force = 1'b0;
    logic        thr_duty = 1'b0;
    logic        stpclk_n;
    logic [1:0]  sleep_lvl;
    logic        thr_act;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sleep_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .pm_base(pm_base), .c4_on_c3(c4_on_c3),
        .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .rd_data(rd_data), .brk_evt(brk_evt), .thr_en(thr_en),
        .thr_force(thr_force), .thr_duty(thr_duty), .stpclk_n(stpclk_n),
        .sleep_lvl(sleep_lvl), .thr_act(thr_act)
    );

    typedef struct packed {
        logic       v0;
        logic       w0;
        logic [6:0] o0;
        logic       v1;
        logic       w1;
        logic [6:0] o1;
        logic       c4;
        logic [1:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        vec_t'({1'b1,1'b0,7'h14, 1'b0,1'b0,7'h00, 1'b0, 2'd1}), // R3
        vec_t'({1'b1,1'b0,7'h15, 1'b0,1'b0,7'h00, 1'b0, 2'd2}), // R4
        vec_t'({1'b0,1'b0,7'h00, 1'b1,1'b0,7'h16, 1'b0, 2'd3}), // R4
        vec_t'({1'b0,1'b0,7'h00, 1'b1,1'b0,7'h15, 1'b1, 2'd3}), // R5
        vec_t'({1'b1,1'b0,7'h16, 1'b0,1'b0,7'h00, 1'b1, 2'd3}), // R5
        vec_t'({1'b1,1'b0,7'h14, 1'b1,1'b0,7'h15, 1'b0, 2'd1}), // R6
        vec_t'({1'b1,1'b0,7'h15, 1'b1,1'b0,7'h14, 1'b1, 2'd1}), // R6
        vec_t'({1'b1,1'b0,7'h15, 1'b1,1'b0,7'h16, 1'b0, 2'd3}), // R6
        vec_t'({1'b1,1'b0,7'h16, 1'b1,1'b0,7'h14, 1'b0, 2'd1}), // R6
        vec_t'({1'b1,1'b0,7'h13, 1'b1,1'b0,7'h17, 1'b0, 2'd0}), // R1
        vec_t'({1'b1,1'b0,7'h54, 1'b0,1'b0,7'h00, 1'b0, 2'd0}), // R1
        vec_t'({1'b1,1'b1,7'h14, 1'b1,1'b1,7'h16, 1'b0, 2'd0}), // R2
        vec_t'({1'b0,1'b0,7'h14, 1'b0,1'b0,7'h15, 1'b0, 2'd0})  // R1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_break();
        @(negedge clk);
        brk_evt = 1'b1;
        @(negedge clk);
        brk_evt = 1'b0;
    endtask

    task automatic access(input logic v0, input logic w0, input logic [15:0] a0,
                          input logic v1, input logic w1, input logic [15:0] a1);
        @(negedge clk);
        acc_valid = {v1, v0};
        acc_wr    = {w1, w0};
        acc_addr  = {a1, a0};
        @(negedge clk);
        acc_valid = '0;
        acc_wr    = '0;
    endtask

    function automatic logic [15:0] at(input logic [6:0] ofs);
        return {BASE, ofs};
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset level", 32'(sleep_lvl), 0);
        check("R11 reset stpclk", 32'(stpclk_n), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            c4_on_c3 = VECS[i].c4;
            // Offset 54h has bit 6 set: same low offset bits, treat as other offset
            access(VECS[i].v0, VECS[i].w0, at(VECS[i].o0),
                   VECS[i].v1, VECS[i].w1, at(VECS[i].o1));
            check($sformatf("R6 vector %0d level", i), 32'(sleep_lvl), 32'(VECS[i].exp));
            check($sformatf("R9 vector %0d stpclk", i), 32'(stpclk_n), 32'(VECS[i].exp == 2'd0));
            check($sformatf("R2 vector %0d rd_data", i), 32'(rd_data), 0);
            if (sleep_lvl != 2'd0) pulse_break();
        end
        c4_on_c3 = 1'b0;

        // R1: wrong base, correct offset
        access(1'b1, 1'b0, 16'h0814, 1'b0, 1'b0, 16'h0);
        check("R1 other base", 32'(sleep_lvl), 0);

        // R7: hold until break, then release
        access(1'b1, 1'b0, at(7'h15), 1'b0, 1'b0, 16'h0);
        repeat (5) @(negedge clk);
        check("R7 hold", 32'(sleep_lvl), 2);
        // R8: deeper trigger while asleep is ignored
        access(1'b1, 1'b0, at(7'h16), 1'b0, 1'b0, 16'h0);
        check("R8 ignore while asleep", 32'(sleep_lvl), 2);
        access(1'b1, 1'b0, at(7'h14), 1'b0, 1'b0, 16'h0);
        check("R8 ignore L2 while asleep", 32'(sleep_lvl), 2);
        // R10: throttle blocked in sleep
        thr_en = 1'b1; thr_duty = 1'b1;
        @(negedge clk);
        check("R10 thr blocked", 32'(thr_act), 0);
        thr_en = 1'b0; thr_duty = 1'b0;
        pulse_break();
        check("R7 break level", 32'(sleep_lvl), 0);
        check("R7 break stpclk", 32'(stpclk_n), 1);

        // R8: trigger in same cycle as break is dropped
        access(1'b1, 1'b0, at(7'h14), 1'b0, 1'b0, 16'h0);
        check("R3 entry", 32'(sleep_lvl), 1);
        @(negedge clk);
        brk_evt = 1'b1;
        acc_valid = 2'b01; acc_wr = '0; acc_addr = {16'h0, at(7'h16)};
        @(negedge clk);
        brk_evt = 1'b0; acc_valid = '0;
        check("R8 trigger with break", 32'(sleep_lvl), 0);
        @(negedge clk);
        check("R8 still run", 32'(sleep_lvl), 0);

        // R10: throttle in run
        thr_force = 1'b1; thr_duty = 1'b1;
        #1;
        check("R10 force throttle act", 32'(thr_act), 1);
        check("R10 force throttle stpclk", 32'(stpclk_n), 0);
        thr_duty = 1'b0;
        #1;
        check("R10 duty off", 32'(stpclk_n), 1);
        thr_force = 1'b0; thr_en = 1'b1; thr_duty = 1'b1;
        #1;
        check("R10 enable throttle act", 32'(thr_act), 1);
        thr_en = 1'b0;
        #1;
        check("R10 no source", 32'(thr_act), 0);
        thr_duty = 1'b0;

        // R10: throttle active then C2 entered
        thr_en = 1'b1; thr_duty = 1'b1;
        access(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, at(7'h14));
        check("R10 C2 overrides throttle", 32'(thr_act), 0);
        check("R9 C2 stpclk", 32'(stpclk_n), 0);
        pulse_break();
        check("R10 throttle resumes", 32'(thr_act), 1);
        thr_en = 1'b0; thr_duty = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule